// File: doc/BRIEF.md
# Trigger Port Match Unit

This block watches one trigger word, sampled on every rising clock edge, and decides whether it satisfies a condition that is set up at run time. Each bit of the word carries its own three-bit qualifier. A qualifier can ask for a fixed level, can mark the bit as ignored, or can ask for a transition measured against the sample from the previous clock. A function select then picks one of eight tests: the bit-wise pattern test, its inverse, four unsigned magnitude tests against an operand, an inclusive range test, and the inverse of the range test.

A registered raw match flag reports the outcome one clock after the word is sampled. An optional event counter, sized by a parameter and absent when that parameter is zero, can be switched on at run time. When on, it drives a second output. That output rises only once a programmed number of raw matches has been seen, and it stays high until the unit is re-armed.

A parameter fixes which comparison family is built into a given instance: level-only, level with edges, magnitude, magnitude with edges, range, or range with edges. A family that is not built returns no match for the tests it lacks. The requirements below describe the default family, range with edges.

Top module: `trig_match_unit`

## Requirements
- R1: Qualifier codes per bit (bits 3i+2..3i of `qual_i` for trigger bit i) are 0 = bit must be 0, 1 = bit must be 1, 2 = ignored, 3 = rising (previous 0, now 1), 4 = falling (previous 1, now 0), 5 = any change, 6 = no change, 7 = ignored. With `func_i` = 0 (pattern), a match needs every bit to satisfy its qualifier.
- R2: With `func_i` = 1 (not pattern), the result is the exact complement of the `func_i` = 0 result for the same inputs.
- R3: The edge qualifiers (codes 3 to 6) compare each bit with the trigger word sampled on the previous clock edge.
- R4: On the first clock edge after reset, no bit with an edge qualifier is satisfied, so no condition that needs an edge can match.
- R5: `func_i` codes 2, 3, 4 and 5 test word > `opa_i`, word >= `opa_i`, word < `opa_i` and word <= `opa_i`, all unsigned. These tests also need every edge-qualified bit to be satisfied.
- R6: In the magnitude and range tests, only bits whose qualifier is 0 or 1 take part. All other bits are forced to zero in the word, in `opa_i` and in `opb_i` before the comparison.
- R7: `func_i` = 6 matches when `opa_i` <= word <= `opb_i`, with both bounds included. `func_i` = 7 matches when that range test fails. Both codes also need every edge-qualified bit to be satisfied.
- R8: `raw_hit_o` is a registered flag. It is high in the cycle after the clock edge at which the word and configuration met the condition, and it carries no other delay.
- R9: When `cnt_en_i` is high, each raw match adds one to a counter. `cnt_hit_o` goes high together with the raw match that brings the count to `cnt_target_i` (a target of 0 acts as 1). The counter then stops and `cnt_hit_o` stays high.
- R10: When `rearm_i` is high at a clock edge, the counter and the held output are cleared, and any match at that same edge is not counted.
- R11: When `cnt_en_i` is low, `cnt_hit_o` equals `raw_hit_o` and the counter keeps its value.
- R12: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | WIDTH | Trigger word under test |
| qual_i | input | 3*WIDTH | Per-bit qualifier codes, three bits per trigger bit |
| func_i | input | 3 | Comparison function select |
| opa_i | input | WIDTH | Magnitude operand and lower range bound |
| opb_i | input | WIDTH | Upper range bound |
| cnt_target_i | input | max(CNT_W,1) | Number of matches required by the counter |
| cnt_en_i | input | 1 | Routes the counter onto `cnt_hit_o` and allows it to count |
| rearm_i | input | 1 | Clears the counter and the held counted output |
| raw_hit_o | output | 1 | Registered match of the selected function |
| cnt_hit_o | output | 1 | Counted match, or the raw match when counting is off |

## Verification
The bench aims at four corner cases: the range bounds themselves and their neighbours one step outside, edge qualifiers on the first sample after a reset, and a re-arm pulse that lands on the same edge as a match. A design with an exclusive bound would miss the endpoints. A design that primes the previous-sample register from reset would report a false edge. A design that lets a match win over a re-arm would leave the counter at one. Ignored bits are mixed into the magnitude tests, so a design that masks only one operand would compare the wrong numbers. The counted output is also checked while matches keep arriving after the target is reached, and the bench switches `cnt_en_i` off to confirm that the output falls back to the raw flag.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

   typedef enum logic [2:0] {
      Q_LOW    = 3'd0,
      Q_HIGH   = 3'd1,
      Q_IGNORE = 3'd2,
      Q_RISE   = 3'd3,
      Q_FALL   = 3'd4,
      Q_TOGGLE = 3'd5,
      Q_STEADY = 3'd6,
      Q_SPARE  = 3'd7
   } qual_e;

   typedef enum logic [2:0] {
      F_PAT    = 3'd0,
      F_NPAT   = 3'd1,
      F_GT     = 3'd2,
      F_GE     = 3'd3,
      F_LT     = 3'd4,
      F_LE     = 3'd5,
      F_INRNG  = 3'd6,
      F_OUTRNG = 3'd7
   } func_e;

   localparam int KIND_LEVEL      = 0;
   localparam int KIND_LEVEL_EDGE = 1;
   localparam int KIND_MAG        = 2;
   localparam int KIND_MAG_EDGE   = 3;
   localparam int KIND_RANGE      = 4;
   localparam int KIND_RANGE_EDGE = 5;

   function automatic bit kind_has_edges(int k);
      return (k == KIND_LEVEL_EDGE) || (k == KIND_MAG_EDGE) || (k == KIND_RANGE_EDGE);
   endfunction

   function automatic bit kind_has_mag(int k);
      return k >= KIND_MAG;
   endfunction

   function automatic bit kind_has_range(int k);
      return k >= KIND_RANGE;
   endfunction

endpackage

// File: rtl/tmu_bit_qual.sv
module tmu_bit_qual
   import tmu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit HAS_EDGES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   trig_i,
   input  logic [3*WIDTH-1:0] qual_i,
   output logic [WIDTH-1:0]   lvl_ok_o,
   output logic [WIDTH-1:0]   edge_ok_o,
   output logic [WIDTH-1:0]   care_o
);

   logic [WIDTH-1:0] prev_q;
   logic             prev_ok_q;

   generate
      if (HAS_EDGES) begin : g_hist
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q    <= '0;
               prev_ok_q <= 1'b0;
            end else begin
               prev_q    <= trig_i;
               prev_ok_q <= 1'b1;
            end
         end
      end else begin : g_nohist
         assign prev_q    = '0;
         assign prev_ok_q = 1'b0;
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         qual_e q;
         logic  lvl, edg;
         assign q = qual_e'(qual_i[3*i +: 3]);

         always_comb begin
            lvl = 1'b1;
            edg = 1'b1;
            unique case (q)
               Q_LOW:    lvl = ~trig_i[i];
               Q_HIGH:   lvl = trig_i[i];
               Q_RISE:   if (HAS_EDGES) edg = prev_ok_q & ~prev_q[i] & trig_i[i];
               Q_FALL:   if (HAS_EDGES) edg = prev_ok_q & prev_q[i] & ~trig_i[i];
               Q_TOGGLE: if (HAS_EDGES) edg = prev_ok_q & (prev_q[i] ^ trig_i[i]);
               Q_STEADY: if (HAS_EDGES) edg = prev_ok_q & ~(prev_q[i] ^ trig_i[i]);
               default:  ;
            endcase
         end

         assign lvl_ok_o[i]  = lvl;
         assign edge_ok_o[i] = edg;
         assign care_o[i]    = (q == Q_LOW) || (q == Q_HIGH);
      end
   endgenerate

endmodule

// File: rtl/tmu_word_cmp.sv
module tmu_word_cmp
   import tmu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit HAS_MAG   = 1'b1,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic [WIDTH-1:0] trig_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [WIDTH-1:0] care_i,
   input  logic [WIDTH-1:0] lvl_ok_i,
   input  logic [WIDTH-1:0] edge_ok_i,
   input  logic [2:0]       func_i,
   output logic             hit_o
);

   logic [WIDTH-1:0] word_m, lo_m, hi_m;
   logic             pat_ok, edges_ok, mag_hit, rng_hit;
   func_e            fsel;

   assign word_m   = trig_i & care_i;
   assign lo_m     = opa_i  & care_i;
   assign hi_m     = opb_i  & care_i;
   assign pat_ok   = &(lvl_ok_i & edge_ok_i);
   assign edges_ok = &edge_ok_i;
   assign fsel     = func_e'(func_i);

   generate
      if (HAS_MAG) begin : g_mag
         always_comb begin
            unique case (fsel)
               F_GT:    mag_hit = word_m >  lo_m;
               F_GE:    mag_hit = word_m >= lo_m;
               F_LT:    mag_hit = word_m <  lo_m;
               F_LE:    mag_hit = word_m <= lo_m;
               default: mag_hit = 1'b0;
            endcase
         end
      end else begin : g_nomag
         assign mag_hit = 1'b0;
      end

      if (HAS_RANGE) begin : g_rng
         logic inside_r;
         assign inside_r = (word_m >= lo_m) && (word_m <= hi_m);
         assign rng_hit  = (fsel == F_INRNG)  ?  inside_r :
                           (fsel == F_OUTRNG) ? ~inside_r : 1'b0;
      end else begin : g_norng
         assign rng_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (fsel)
         F_PAT:             hit_o = pat_ok;
         F_NPAT:            hit_o = ~pat_ok;
         F_INRNG, F_OUTRNG: hit_o = edges_ok & rng_hit;
         default:           hit_o = edges_ok & mag_hit;
      endcase
   end

endmodule

// File: rtl/tmu_event_count.sv
module tmu_event_count #(
   parameter int CNT_W = 8,
   localparam int TGT_W = (CNT_W == 0) ? 1 : CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             raw_q_i,
   input  logic             en_i,
   input  logic             rearm_i,
   input  logic [TGT_W-1:0] target_i,
   output logic             cnt_hit_o
);

   generate
      if (CNT_W == 0) begin : g_nocnt
         assign cnt_hit_o = raw_q_i;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W:0]   cnt_nxt;
         logic             done_q;

         assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (rearm_i) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (en_i && hit_i && !done_q) begin
               cnt_q <= cnt_nxt[CNT_W-1:0];
               if (cnt_nxt >= {1'b0, target_i}) done_q <= 1'b1;
            end
         end

         assign cnt_hit_o = en_i ? done_q : raw_q_i;
      end
   endgenerate

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit #(
   parameter int WIDTH = 16,
   parameter int CNT_W = 8,
   parameter int KIND  = tmu_pkg::KIND_RANGE_EDGE,
   localparam int TGT_W = (CNT_W == 0) ? 1 : CNT_W,
   localparam int QW    = 3 * WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] trig_i,
   input  logic [QW-1:0]    qual_i,
   input  logic [2:0]       func_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [TGT_W-1:0] cnt_target_i,
   input  logic             cnt_en_i,
   input  logic             rearm_i,
   output logic             raw_hit_o,
   output logic             cnt_hit_o
);

   localparam bit HAS_EDGES = tmu_pkg::kind_has_edges(KIND);
   localparam bit HAS_MAG   = tmu_pkg::kind_has_mag(KIND);
   localparam bit HAS_RANGE = tmu_pkg::kind_has_range(KIND);

   generate
      if (WIDTH < 1 || WIDTH > 256) begin : g_bad_width
         $error("trig_match_unit: WIDTH must lie in 1..256");
      end
      if (CNT_W < 0 || CNT_W > 32) begin : g_bad_cnt
         $error("trig_match_unit: CNT_W must lie in 0..32");
      end
      if (KIND < tmu_pkg::KIND_LEVEL || KIND > tmu_pkg::KIND_RANGE_EDGE) begin : g_bad_kind
         $error("trig_match_unit: KIND out of range");
      end
   endgenerate

   logic [WIDTH-1:0] lvl_ok, edge_ok, care;
   logic             hit_c, raw_q;

   tmu_bit_qual #(.WIDTH(WIDTH), .HAS_EDGES(HAS_EDGES)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_i),
      .qual_i    (qual_i),
      .lvl_ok_o  (lvl_ok),
      .edge_ok_o (edge_ok),
      .care_o    (care)
   );

   tmu_word_cmp #(.WIDTH(WIDTH), .HAS_MAG(HAS_MAG), .HAS_RANGE(HAS_RANGE)) u_cmp (
      .trig_i    (trig_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .care_i    (care),
      .lvl_ok_i  (lvl_ok),
      .edge_ok_i (edge_ok),
      .func_i    (func_i),
      .hit_o     (hit_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= hit_c;
   end

   assign raw_hit_o = raw_q;

   tmu_event_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit_c),
      .raw_q_i   (raw_q),
      .en_i      (cnt_en_i),
      .rearm_i   (rearm_i),
      .target_i  (cnt_target_i),
      .cnt_hit_o (cnt_hit_o)
   );

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
   parameter int WIDTH = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [3*WIDTH-1:0] qual_i,
   input logic [2:0]         func_i,
   input logic               cnt_en_i,
   input logic               rearm_i,
   input logic               raw_hit_o,
   input logic               cnt_hit_o
);

   logic first_q, all_ign, all_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   always_comb begin
      all_ign  = 1'b1;
      all_edge = 1'b1;
      for (int i = 0; i < WIDTH; i++) begin
         if (!(qual_i[3*i +: 3] == 3'd2 || qual_i[3*i +: 3] == 3'd7)) all_ign = 1'b0;
         if (qual_i[3*i +: 3] < 3'd3 || qual_i[3*i +: 3] > 3'd6)      all_edge = 1'b0;
      end
   end

   AST_IGNORED_PATTERN_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (func_i == 3'd0 && all_ign) |=> raw_hit_o); // R1

   AST_IGNORED_INVERSE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
      (func_i == 3'd1 && all_ign) |=> !raw_hit_o); // R2

   AST_NO_EDGE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q && all_edge && func_i == 3'd0) |=> !raw_hit_o); // R4

   AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_i && cnt_hit_o && !rearm_i) |=> (cnt_hit_o || !cnt_en_i)); // R9

   AST_COUNT_RISE_WITH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cnt_hit_o) && cnt_en_i && $past(cnt_en_i)) |-> raw_hit_o); // R9

   AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_i |=> (!cnt_en_i || !cnt_hit_o)); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!raw_hit_o && !cnt_hit_o)); // R12

endmodule

bind trig_match_unit tmu_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .qual_i    (qual_i),
   .func_i    (func_i),
   .cnt_en_i  (cnt_en_i),
   .rearm_i   (rearm_i),
   .raw_hit_o (raw_hit_o),
   .cnt_hit_o (cnt_hit_o)
);

// File: tb/trig_match_unit_tb_top.sv
module trig_match_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TW = 8;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TW-1:0]   trig = '0;
   logic [3*TW-1:0] qual = '0;
   logic [2:0]      func = '0;
   logic [TW-1:0]   opa = '0, opb = '0;
   logic [CW-1:0]   tgt = '0;
   logic            cen = 1'b0, rearm = 1'b0;
   logic            raw_hit_o, cnt_hit_o;

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string cur_req = "R12";

   // reference model state
   logic [TW-1:0] m_prev = '0;
   bit            m_pok = 0, m_raw = 0, m_done = 0;
   int            m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_match_unit #(.WIDTH(TW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .qual_i(qual), .func_i(func),
      .opa_i(opa), .opb_i(opb), .cnt_target_i(tgt), .cnt_en_i(cen),
      .rearm_i(rearm), .raw_hit_o(raw_hit_o), .cnt_hit_o(cnt_hit_o));

   function automatic bit model_hit();
      bit lvl = 1, edg = 1;
      int tv = 0, av = 0, bv = 0;
      for (int i = 0; i < TW; i++) begin
         int q = int'(qual[3*i +: 3]);
         bit t = trig[i], p = m_prev[i];
         case (q)
            0: begin if (t)  lvl = 0; tv += int'(t) << i; av += int'(opa[i]) << i; bv += int'(opb[i]) << i; end
            1: begin if (!t) lvl = 0; tv += int'(t) << i; av += int'(opa[i]) << i; bv += int'(opb[i]) << i; end
            3: if (!(m_pok && !p && t)) edg = 0;
            4: if (!(m_pok && p && !t)) edg = 0;
            5: if (!(m_pok && p != t))  edg = 0;
            6: if (!(m_pok && p == t))  edg = 0;
            default: ;
         endcase
      end
      case (func)
         3'd0: return lvl && edg;
         3'd1: return !(lvl && edg);
         3'd2: return edg && tv >  av;
         3'd3: return edg && tv >= av;
         3'd4: return edg && tv <  av;
         3'd5: return edg && tv <= av;
         3'd6: return edg && (av <= tv && tv <= bv);
         default: return edg && !(av <= tv && tv <= bv);
      endcase
   endfunction

   task automatic model_update();
      bit h;
      if (!rst_n) begin
         m_prev = '0; m_pok = 0; m_raw = 0; m_cnt = 0; m_done = 0;
         return;
      end
      h = model_hit();
      if (rearm) begin
         m_cnt = 0; m_done = 0;
      end else if (cen && h && !m_done) begin
         m_cnt++;
         if (m_cnt >= int'(tgt)) m_done = 1;
      end
      m_raw  = h;
      m_prev = trig;
      m_pok  = 1;
   endtask

   task automatic compare();
      bit e_cnt;
      e_cnt = cen ? m_done : m_raw;
      n_cmp++;
      if (raw_hit_o !== m_raw) begin
         n_bad++;
         $display("FAIL %s raw_hit_o actual=%0b expected=%0b cycle=%0d", cur_req, raw_hit_o, m_raw, cyc);
      end
      n_cmp++;
      if (cnt_hit_o !== e_cnt) begin
         n_bad++;
         $display("FAIL %s cnt_hit_o actual=%0b expected=%0b cycle=%0d", cur_req, cnt_hit_o, e_cnt, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_update();
      cyc++;
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      cur_req = "R12";
      rst_n = 1'b0;
      for (int k = 0; k < 3; k++) tick();
      rst_n = 1'b1;
   endtask

   // levels only (codes 0,1,2); returns qual and a trigger matching it or off by one bit
   task automatic level_stim(input bit near);
      for (int i = 0; i < TW; i++) qual[3*i +: 3] = 3'($urandom_range(0, 2));
      trig = TW'($urandom);
      for (int i = 0; i < TW; i++) begin
         if (qual[3*i +: 3] == 3'd0) trig[i] = 1'b0;
         if (qual[3*i +: 3] == 3'd1) trig[i] = 1'b1;
      end
      if (near && $urandom_range(0, 1) == 1) trig[$urandom_range(0, TW-1)] ^= 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1: level pattern equality
      cur_req = "R1"; func = 3'd0;
      for (int k = 0; k < 60; k++) begin level_stim(1); tick(); end
      qual = {TW{3'd7}}; tick();

      // R2: inverse pattern
      cur_req = "R2"; func = 3'd1;
      for (int k = 0; k < 60; k++) begin level_stim(1); tick(); end

      // R3: edge qualifiers against previous sample
      cur_req = "R3"; func = 3'd0;
      for (int k = 0; k < 120; k++) begin
         for (int i = 0; i < TW; i++)
            qual[3*i +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(3, 6)) : 3'd2;
         trig = trig ^ TW'($urandom_range(0, 3) << $urandom_range(0, TW-2));
         tick();
      end
      qual = '0; qual[2:0] = 3'd3; trig = 8'h00; tick(); trig = 8'h01; tick(); trig = 8'h01; tick();

      // R4: edges cannot match on first sample after reset
      qual = {TW{3'd5}}; trig = 8'h55;
      do_reset();
      cur_req = "R4";
      trig = 8'hAA; tick(); trig = 8'h55; tick(); trig = 8'hAA; tick();
      qual = {TW{3'd6}}; do_reset(); cur_req = "R4"; tick(); tick();

      // R5: unsigned magnitude
      cur_req = "R5";
      for (int k = 0; k < 120; k++) begin
         func = 3'($urandom_range(2, 5));
         for (int i = 0; i < TW; i++) qual[3*i +: 3] = 3'($urandom_range(0, 1));
         trig = TW'($urandom);
         opa  = ($urandom_range(0, 3) == 0) ? trig : TW'($urandom);
         tick();
      end
      qual = '0; func = 3'd2; trig = 8'hFF; opa = 8'h7F; tick();
      func = 3'd4; trig = 8'h00; opa = 8'h80; tick();

      // R6: ignored bits forced to zero on both sides
      cur_req = "R6";
      for (int k = 0; k < 120; k++) begin
         func = 3'($urandom_range(2, 7));
         for (int i = 0; i < TW; i++) qual[3*i +: 3] = 3'($urandom_range(0, 2)) | (($urandom_range(0, 5) == 0) ? 3'd7 : 3'd0);
         trig = TW'($urandom); opa = TW'($urandom); opb = TW'($urandom);
         tick();
      end

      // R7: inclusive range and its complement
      cur_req = "R7"; qual = '0;
      for (int k = 0; k < 120; k++) begin
         int lo = $urandom_range(1, 120);
         int hi = lo + $urandom_range(0, 120);
         int pick = $urandom_range(0, 4);
         func = 3'($urandom_range(6, 7));
         opa = TW'(lo); opb = TW'(hi);
         trig = (pick == 0) ? TW'(lo - 1) : (pick == 1) ? TW'(lo) :
                (pick == 2) ? TW'(hi) : (pick == 3) ? TW'(hi + 1) : TW'($urandom);
         tick();
      end
      for (int i = 0; i < TW; i++) qual[3*i +: 3] = 3'd6;
      qual[2:0] = 3'd3; func = 3'd6; opa = 0; opb = 8'hFF;
      trig = 8'h00; tick(); trig = 8'h01; tick(); trig = 8'h01; tick();

      // R8: single-cycle pulses appear one cycle later only
      cur_req = "R8"; qual = {TW{3'd2}};
      for (int k = 0; k < 30; k++) begin
         func = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'd1;
         tick();
      end

      // R9: counter to target, saturation, hold
      cur_req = "R9"; cen = 1'b1; tgt = 4'd5; rearm = 1'b1; tick(); rearm = 1'b0;
      for (int k = 0; k < 40; k++) begin
         func = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd1;
         tick();
      end
      tgt = 4'd0; rearm = 1'b1; tick(); rearm = 1'b0; func = 3'd1; tick(); func = 3'd0; tick(); tick();
      tgt = 4'd15; rearm = 1'b1; tick(); rearm = 1'b0; func = 3'd0;
      for (int k = 0; k < 20; k++) tick();

      // R10: rearm clears, match on the rearm edge not counted
      cur_req = "R10"; tgt = 4'd2;
      for (int k = 0; k < 80; k++) begin
         func  = ($urandom_range(0, 2) == 0) ? 3'd1 : 3'd0;
         rearm = ($urandom_range(0, 4) == 0);
         tick();
      end
      rearm = 1'b0;

      // R11: counter disabled follows raw, count held
      cur_req = "R11"; tgt = 4'd3; rearm = 1'b1; tick(); rearm = 1'b0;
      func = 3'd0; tick(); tick();
      cen = 1'b0;
      for (int k = 0; k < 40; k++) begin
         func = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd1;
         tick();
      end
      cen = 1'b1; func = 3'd1; tick(); func = 3'd0; tick(); tick();

      do_reset();
      summary();
      $finish;
   end

endmodule